// File: doc/BRIEF.md
# ATA Device Task-File Register Model

This block models the device side of one parallel ATA bus holding a master drive and an optional slave drive. A host reaches it through byte-wide register reads and writes. A port offset picks a command-block register, and a separate select line picks the control block, which is the device control register on write and the alternate status register on read. Each drive keeps its own copy of the count and address registers. The drive/head register is shared by the bus, and one bit of it picks which drive answers.

Commands are not executed against any media. A write to the command register starts a stub engine that stays busy for a programmable number of cycles. It then ends in one of four ways: a plain success, a success with a data request, an abort error, or a device fault. The ending is reported through the status flags and through the interrupt line. A bus-wide software reset and a per-drive interrupt mask follow the shared-wire rules for two drives on one bus.

Top module: `ata_taskfile_dev`

## Requirements
- R1: The drive/head register (offset 6) reads back the last value written. Its bit 4 selects the slave (1) or the master (0), and bit 6 holds the LBA-mode flag. After reset it reads 0xA0, which selects the master.
- R2: Offsets 2 to 5 (count, LBA low, LBA mid, LBA high) are kept per drive and read back the last value written to that drive. Writes and reads go to the slave copy only when the slave is present and selected; otherwise they go to the master copy.
- R3: A control-block write with bit 2 set starts a software reset of both drives. While it is held, status reads 0x80 and drive/head writes are ignored. At the next edge each drive's offsets 2..5 load 0x01, 0x01, 0x00, 0x00, its error register loads 0x01, its flags clear and any running command is dropped. Once bit 2 is written back to 0, the drive/head register reads 0xA0 and the master is selected.
- R4: Control bit 1 (interrupt mask) is stored only into the currently selected drive, and only when that drive is present. A drive keeps its mask until it is selected again and a new value is written.
- R5: Status is encoded as BSY 0x80, ready 0x40 (shown while not busy), DF 0x20, DRQ 0x08 and ERR 0x01. A write to offset 7 starts a command on the selected drive if that drive is present and the engine is idle. BSY is then shown for exactly LATENCY cycles. A command write while the engine is busy is ignored. Command 0x20 ends with DRQ set.
- R6: Command 0x00 ends with ERR set and error register 0x04, and command 0xFE ends with DF set. On either ending BSY and DRQ are clear. The error flag stays until the next accepted command write, and an error ending never raises the interrupt.
- R7: A successful ending makes an interrupt pending. irq_out is high while the interrupt is pending, the drive that ran the command is selected, and that drive's mask is 0. A read of offset 7 on that drive clears the pending interrupt; a control-block (alternate status) read does not.
- R8: With the slave absent and selected, status and alternate status read 0x00, and command writes are ignored.
- R9: Offset 0 (data) reads 0x00. Offset 1 reads the error register of the drive that answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_present | input | 1 | Strap: a slave drive is attached |
| host_ctl | input | 1 | 1 selects the control block (device control / alternate status) |
| host_addr | input | 3 | Command-block register offset |
| host_wr | input | 1 | Register write strobe, one cycle per write |
| host_rd | input | 1 | Register read strobe, one cycle per read |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed register |
| irq_out | output | 1 | Interrupt request to the host |

## Verification
The bench builds the block with LATENCY set to 3. This keeps the busy window short enough that reads during BSY, a second command write landing while busy, and the ending edge all fall inside a few cycles of a directed sequence. The slave strap is driven high in the first phase and low after a second reset. This brings in both the two-drive selection, mask and reset behaviour and the missing-slave case, where status reads zero and all other accesses go to the master.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam int NUM_DRIVES = 2;
    localparam int TF_REGS    = 4;

    typedef enum logic [2:0] {
        OFS_DATA    = 3'd0,
        OFS_ERROR   = 3'd1,
        OFS_COUNT   = 3'd2,
        OFS_LBA_LO  = 3'd3,
        OFS_LBA_MID = 3'd4,
        OFS_LBA_HI  = 3'd5,
        OFS_DEVSEL  = 3'd6,
        OFS_CMDSTAT = 3'd7
    } tf_ofs_e;

    typedef struct packed {
        logic err;
        logic df;
        logic drq;
    } drv_flags_t;

    typedef struct packed {
        logic valid;
        logic err;
        logic df;
        logic xfer;
    } cmd_done_t;

    localparam logic [7:0] DEVSEL_RESET   = 8'hA0;
    localparam logic [7:0] STATUS_IN_SRST = 8'h80;
    localparam logic [7:0] ERRREG_ABORT   = 8'h04;
    localparam logic [7:0] ERRREG_DIAG    = 8'h01;

    function automatic logic [7:0] status_byte(logic bsy, drv_flags_t f);
        return {bsy, ~bsy, f.df, 1'b0, f.drq, 2'b00, f.err};
    endfunction

    function automatic logic [7:0] reset_signature(int idx);
        return (idx < 2) ? 8'h01 : 8'h00;
    endfunction

endpackage

// File: rtl/ata_tf_cmd_engine.sv
module ata_tf_cmd_engine
    import ata_tf_pkg::*;
#(
    parameter int         LATENCY   = 8,
    parameter logic [7:0] CMD_ABORT = 8'h00,
    parameter logic [7:0] CMD_FAULT = 8'hFE,
    parameter logic [7:0] CMD_XFER  = 8'h20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       srst,
    input  logic       start,
    input  logic       start_drv,
    input  logic [7:0] cmd,
    output logic       busy,
    output logic       busy_drv,
    output cmd_done_t  done
);
    localparam int CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(LATENCY - 1);

    logic [CW-1:0] cnt_q;
    logic [7:0]    cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            busy_drv <= 1'b0;
            cnt_q    <= '0;
            cmd_q    <= '0;
        end else if (srst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            busy_drv <= start_drv;
            cnt_q    <= CNT_LOAD;
            cmd_q    <= cmd;
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        done.valid = busy && (cnt_q == '0) && !srst;
        done.err   = (cmd_q == CMD_ABORT);
        done.df    = (cmd_q == CMD_FAULT) && (cmd_q != CMD_ABORT);
        done.xfer  = (cmd_q == CMD_XFER);
    end

    // R5: the top must never start a command over a running one
    assert_no_restart_R5: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    // R5: an accepted start makes the engine busy on the next cycle
    assert_start_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !srst) |=> busy);

endmodule

// File: rtl/ata_tf_drive.sv
module ata_tf_drive
    import ata_tf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     srst,
    input  logic                     tf_we,
    input  logic [1:0]               tf_idx,
    input  logic [7:0]               wdata,
    input  logic                     nien_we,
    input  logic                     nien_in,
    input  logic                     cmd_start,
    input  cmd_done_t                done,
    input  logic                     done_hit,
    output logic [TF_REGS-1:0][7:0]  tf_rd,
    output logic [7:0]               errreg,
    output drv_flags_t               flags,
    output logic                     nien
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tf_rd  <= '0;
            errreg <= '0;
            flags  <= '0;
        end else if (srst) begin
            for (int i = 0; i < TF_REGS; i++) tf_rd[i] <= reset_signature(i);
            errreg <= ERRREG_DIAG;
            flags  <= '0;
        end else begin
            if (tf_we) tf_rd[tf_idx] <= wdata;
            if (cmd_start) begin
                flags <= '0;
            end else if (done.valid && done_hit) begin
                flags.err <= done.err;
                flags.df  <= done.df;
                flags.drq <= done.xfer && !done.err && !done.df;
                if (done.err) errreg <= ERRREG_ABORT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          nien <= 1'b0;
        else if (nien_we) nien <= nien_in;
    end

    // R4: the mask only moves on a write aimed at this drive
    assert_nien_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !nien_we |=> $stable(nien));
    // R6: at most one ending flag at a time
    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flags.err, flags.df, flags.drq}));

endmodule

// File: rtl/ata_taskfile_dev.sv
module ata_taskfile_dev
    import ata_tf_pkg::*;
#(
    parameter int         LATENCY   = 8,
    parameter logic [7:0] CMD_ABORT = 8'h00,
    parameter logic [7:0] CMD_FAULT = 8'hFE,
    parameter logic [7:0] CMD_XFER  = 8'h20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       slave_present,
    input  logic       host_ctl,
    input  logic [2:0] host_addr,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       irq_out
);
    logic [7:0] devsel_q;
    logic       srst_q;
    logic       irq_pend_q;

    logic sel, tgt, present;
    assign sel     = devsel_q[4];
    assign tgt     = sel & slave_present;
    assign present = ~sel | slave_present;

    logic       blk_wr, ctl_wr, is_tf, cmd_start, stat_rd_clr;
    logic [1:0] tf_idx;
    assign blk_wr = host_wr & ~host_ctl;
    assign ctl_wr = host_wr & host_ctl;
    assign is_tf  = (host_addr >= OFS_COUNT) && (host_addr <= OFS_LBA_HI);
    assign tf_idx = host_addr[1:0] - 2'd2;

    logic      eng_busy, eng_drv;
    cmd_done_t eng_done;

    assign cmd_start   = blk_wr && (host_addr == OFS_CMDSTAT) && present
                         && !eng_busy && !srst_q;
    assign stat_rd_clr = host_rd && !host_ctl && (host_addr == OFS_CMDSTAT)
                         && present && (eng_drv == sel);

    logic [TF_REGS-1:0][7:0] tf_rd  [NUM_DRIVES];
    logic [7:0]              errreg [NUM_DRIVES];
    drv_flags_t              flg    [NUM_DRIVES];
    logic                    nien   [NUM_DRIVES];

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
        ata_tf_drive u_drive (
            .clk       (clk),
            .rst       (rst),
            .srst      (srst_q),
            .tf_we     (blk_wr && is_tf && !srst_q && (tgt == 1'(d))),
            .tf_idx    (tf_idx),
            .wdata     (host_wdata),
            .nien_we   (ctl_wr && present && (sel == 1'(d))),
            .nien_in   (host_wdata[1]),
            .cmd_start (cmd_start && (sel == 1'(d))),
            .done      (eng_done),
            .done_hit  (eng_drv == 1'(d)),
            .tf_rd     (tf_rd[d]),
            .errreg    (errreg[d]),
            .flags     (flg[d]),
            .nien      (nien[d])
        );
    end

    ata_tf_cmd_engine #(
        .LATENCY   (LATENCY),
        .CMD_ABORT (CMD_ABORT),
        .CMD_FAULT (CMD_FAULT),
        .CMD_XFER  (CMD_XFER)
    ) u_engine (
        .clk       (clk),
        .rst       (rst),
        .srst      (srst_q),
        .start     (cmd_start),
        .start_drv (sel),
        .cmd       (host_wdata),
        .busy      (eng_busy),
        .busy_drv  (eng_drv),
        .done      (eng_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            devsel_q   <= DEVSEL_RESET;
            srst_q     <= 1'b0;
            irq_pend_q <= 1'b0;
        end else begin
            if (ctl_wr) srst_q <= host_wdata[2];
            if (srst_q)
                devsel_q <= DEVSEL_RESET;
            else if (blk_wr && host_addr == OFS_DEVSEL)
                devsel_q <= host_wdata;
            if (srst_q)
                irq_pend_q <= 1'b0;
            else if (eng_done.valid && !eng_done.err && !eng_done.df)
                irq_pend_q <= 1'b1;
            else if (cmd_start || stat_rd_clr)
                irq_pend_q <= 1'b0;
        end
    end

    logic [7:0] sel_status, shown_status;
    assign sel_status   = srst_q ? STATUS_IN_SRST
                                 : status_byte(eng_busy && (eng_drv == sel), flg[sel]);
    assign shown_status = present ? sel_status : 8'h00;

    always_comb begin
        if (host_ctl) begin
            host_rdata = shown_status;
        end else begin
            unique case (host_addr)
                OFS_DATA:    host_rdata = 8'h00;
                OFS_ERROR:   host_rdata = errreg[tgt];
                OFS_DEVSEL:  host_rdata = devsel_q;
                OFS_CMDSTAT: host_rdata = shown_status;
                default:     host_rdata = tf_rd[tgt][tf_idx];
            endcase
        end
    end

    assign irq_out = irq_pend_q && !nien[eng_drv] && (eng_drv == sel);

    // R6: an error or fault ending leaves the interrupt low
    assert_err_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (eng_done.valid && (eng_done.err || eng_done.df)) |=> !irq_out);
    // R3: leaving software reset always leaves the master selected
    assert_srst_master_R3: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> !devsel_q[4]);
    // R8: an absent selected slave shows a zero status
    assert_absent_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !slave_present && devsel_q[4]
         && (host_ctl || host_addr == OFS_CMDSTAT)) |-> (host_rdata == 8'h00));
    // R7: an alternate status read keeps a pending interrupt visible
    assert_alt_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_ctl && !host_wr && !srst_q && irq_out) |=> irq_out);

endmodule

// File: tb/ata_taskfile_dev_tb_top.sv
module ata_taskfile_dev_tb_top;
    localparam int LAT = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1, sp = 1'b1, hctl = 1'b0, hwr = 1'b0, hrd = 1'b0;
    logic [2:0] haddr = '0;
    logic [7:0] hwd = '0;
    logic [7:0] hrdata;
    logic       irq;

    ata_taskfile_dev #(.LATENCY(LAT)) dut_i (
        .clk(clk), .rst(rst), .slave_present(sp), .host_ctl(hctl),
        .host_addr(haddr), .host_wr(hwr), .host_rd(hrd), .host_wdata(hwd),
        .host_rdata(hrdata), .irq_out(irq)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_tf [2][4];
    int m_errr[2], m_nien[2], m_err[2], m_df[2], m_drq[2];
    int m_dh, m_srst, m_busy, m_cnt, m_cmd, m_cd, m_pend;

    function automatic int m_stat(int d);
        int b;
        if (m_srst != 0) return 'h80;
        b = (m_busy != 0) && (m_cd == d);
        return (b ? 'h80 : 'h40) | (m_df[d] != 0 ? 'h20 : 0)
             | (m_drq[d] != 0 ? 'h08 : 0) | (m_err[d] != 0 ? 'h01 : 0);
    endfunction

    function automatic int m_read();
        int s, pres, t;
        s = (m_dh >> 4) & 1;
        pres = (s == 0) || sp;
        t = (s == 1 && sp) ? 1 : 0;
        if (hctl) return pres ? m_stat(s) : 0;
        case (int'(haddr))
            0: return 0;
            1: return m_errr[t];
            6: return m_dh;
            7: return pres ? m_stat(s) : 0;
            default: return m_tf[t][int'(haddr) - 2];
        endcase
    endfunction

    function automatic int m_irq();
        int s;
        s = (m_dh >> 4) & 1;
        return (m_pend != 0 && m_cd == s && m_nien[m_cd] == 0) ? 1 : 0;
    endfunction

    function automatic string tag_for();
        if (hctl) return "R7 alt-status read";
        case (int'(haddr))
            0: return "R9 data read";
            1: return "R9 error read";
            6: return "R1 drive/head read";
            7: return "R5 status read";
            default: return "R2 task-file read";
        endcase
    endfunction

    always @(posedge clk) begin
        int s, pres, t, b0;
        s = (m_dh >> 4) & 1;
        pres = (s == 0) || sp;
        t = (s == 1 && sp) ? 1 : 0;
        b0 = m_busy;
        if (rst) begin
            for (int d = 0; d < 2; d++) begin
                for (int i = 0; i < 4; i++) m_tf[d][i] = 0;
                m_errr[d] = 0; m_nien[d] = 0; m_err[d] = 0; m_df[d] = 0; m_drq[d] = 0;
            end
            m_dh = 'hA0; m_srst = 0; m_busy = 0; m_cnt = 0; m_cmd = 0; m_cd = 0; m_pend = 0;
        end else if (m_srst != 0) begin
            for (int d = 0; d < 2; d++) begin
                for (int i = 0; i < 4; i++) m_tf[d][i] = (i < 2) ? 1 : 0;
                m_errr[d] = 1; m_err[d] = 0; m_df[d] = 0; m_drq[d] = 0;
            end
            m_dh = 'hA0; m_busy = 0; m_cnt = 0; m_pend = 0;
            if (hwr && hctl) begin
                m_srst = hwd[2];
                if (pres) m_nien[s] = hwd[1];
            end
        end else begin
            if (hrd && !hctl && haddr == 3'd7 && pres && m_cd == s) m_pend = 0;
            if (b0 != 0) begin
                if (m_cnt == 0) begin
                    m_busy = 0;
                    if (m_cmd == 'h00) begin m_err[m_cd] = 1; m_errr[m_cd] = 4; end
                    else if (m_cmd == 'hFE) m_df[m_cd] = 1;
                    else begin m_drq[m_cd] = (m_cmd == 'h20); m_pend = 1; end
                end else m_cnt--;
            end
            if (hwr) begin
                if (hctl) begin
                    m_srst = hwd[2];
                    if (pres) m_nien[s] = hwd[1];
                end else if (haddr >= 3'd2 && haddr <= 3'd5) m_tf[t][int'(haddr) - 2] = hwd;
                else if (haddr == 3'd6) m_dh = hwd;
                else if (haddr == 3'd7 && pres && b0 == 0) begin
                    m_err[s] = 0; m_df[s] = 0; m_drq[s] = 0;
                    m_busy = 1; m_cnt = LAT - 1; m_cmd = hwd; m_cd = s; m_pend = 0;
                end
            end
        end
    end

    // compare against the model on every clock
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R7 irq vs model", irq, m_irq());
            if (hrd) chk(tag_for(), hrdata, m_read());
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog (all R) actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(bit c, int a, int d);
        hctl = c; haddr = 3'(a); hwd = 8'(d); hwr = 1'b1;
        @(posedge clk); #1;
        hwr = 1'b0; hctl = 1'b0;
    endtask

    task automatic rd_exp(bit c, int a, int exp, string tag);
        hctl = c; haddr = 3'(a); hrd = 1'b1;
        @(negedge clk);
        chk(tag, hrdata, exp);
        @(posedge clk); #1;
        hrd = 1'b0; hctl = 1'b0;
    endtask

    task automatic irq_exp(int exp, string tag);
        @(negedge clk);
        chk(tag, irq, exp);
        @(posedge clk); #1;
    endtask

    task automatic do_reset(bit slave);
        rst = 1'b1; sp = slave;
        idle(3);
        rst = 1'b0;
    endtask

    initial begin
        #1;
        // ---- phase A: slave present ----
        do_reset(1'b1);
        rd_exp(0, 7, 'h40, "R5 reset status master ready");
        rd_exp(0, 6, 'hA0, "R1 reset drive/head");
        irq_exp(0, "R7 reset irq low");
        wr(0, 2, 'h11); wr(0, 3, 'h22); wr(0, 4, 'h33); wr(0, 5, 'h44);
        wr(0, 6, 'hF0);
        rd_exp(0, 6, 'hF0, "R1 drive/head readback slave+LBA");
        wr(0, 2, 'h55); wr(0, 3, 'h66); wr(0, 4, 'h77); wr(0, 5, 'h88);
        rd_exp(0, 2, 'h55, "R2 slave count");
        rd_exp(0, 5, 'h88, "R2 slave lba high");
        wr(0, 6, 'hE0);
        rd_exp(0, 2, 'h11, "R2 master count kept");
        rd_exp(0, 4, 'h33, "R2 master lba mid kept");
        // masks: master masked, slave unmasked
        wr(1, 0, 'h02);
        wr(0, 6, 'hF0); wr(1, 0, 'h00);
        wr(0, 6, 'hE0);
        wr(0, 7, 'hEC);
        rd_exp(0, 7, 'h80, "R5 busy after command");
        idle(5);
        rd_exp(1, 0, 'h40, "R5 master done ready");
        irq_exp(0, "R4 masked master no irq");
        rd_exp(0, 7, 'h40, "R5 status read");
        // slave keeps its own mask
        wr(0, 6, 'hF0);
        wr(0, 7, 'h20);
        idle(5);
        irq_exp(1, "R4 slave unmasked irq");
        rd_exp(1, 0, 'h48, "R5 DRQ ending via alt status");
        irq_exp(1, "R7 alt read keeps irq");
        rd_exp(0, 7, 'h48, "R5 status with DRQ");
        irq_exp(0, "R7 status read clears irq");
        // pending follows selection
        wr(0, 7, 'h20);
        idle(5);
        wr(0, 6, 'hE0);
        irq_exp(0, "R7 deselected drive hides irq");
        wr(0, 6, 'hF0);
        irq_exp(1, "R7 reselect shows irq");
        rd_exp(0, 7, 'h48, "R7 clear read");
        // error endings
        wr(0, 7, 'h00);
        idle(5);
        rd_exp(0, 7, 'h41, "R6 abort sets ERR");
        rd_exp(0, 1, 'h04, "R9 error register abort code");
        irq_exp(0, "R6 no irq on error");
        wr(0, 7, 'hFE);
        rd_exp(0, 7, 'h80, "R6 ERR cleared by new command");
        idle(5);
        rd_exp(0, 7, 'h60, "R6 fault sets DF");
        irq_exp(0, "R6 no irq on fault");
        // command while busy is ignored
        wr(0, 7, 'h20);
        wr(0, 7, 'h00);
        idle(5);
        rd_exp(0, 7, 'h48, "R5 busy command ignored");
        rd_exp(0, 0, 'h00, "R9 data port reads zero");
        // software reset with slave selected
        wr(1, 0, 'h04);
        idle(2);
        rd_exp(0, 7, 'h80, "R3 status during reset");
        rd_exp(0, 6, 'hA0, "R3 drive/head during reset");
        rd_exp(0, 2, 'h01, "R3 count signature");
        rd_exp(0, 4, 'h00, "R3 lba mid signature");
        wr(0, 6, 'hF0);
        rd_exp(0, 6, 'hA0, "R3 drive/head write ignored");
        wr(1, 0, 'h00);
        idle(1);
        rd_exp(0, 6, 'hA0, "R3 master selected after reset");
        rd_exp(0, 7, 'h40, "R3 master ready after reset");
        rd_exp(0, 1, 'h01, "R3 error register after reset");
        wr(0, 6, 'hF0);
        rd_exp(0, 3, 'h01, "R3 slave lba low signature");
        // ---- phase B: slave absent ----
        do_reset(1'b0);
        wr(0, 6, 'hB0);
        rd_exp(0, 7, 'h00, "R8 absent slave status");
        rd_exp(1, 0, 'h00, "R8 absent slave alt status");
        wr(0, 2, 'h99);
        wr(1, 0, 'h02);
        wr(0, 7, 'h20);
        idle(5);
        irq_exp(0, "R8 command to absent slave ignored");
        wr(0, 6, 'hA0);
        rd_exp(0, 2, 'h99, "R2 absent slave writes reach master");
        rd_exp(0, 7, 'h40, "R8 master never started");
        wr(0, 7, 'h20);
        idle(5);
        irq_exp(1, "R4 mask write to absent slave ignored");
        rd_exp(0, 7, 'h48, "R7 final clear");
        idle(2);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule